// File: doc/BRIEF.md
# Mixed Text/Bitmap Scanline Renderer

This block turns the horizontal and vertical pixel counters of a 640x480 timing generator into a 6-bit RGB pixel value. It reads a shared 64 KiB byte-wide display memory through a read port whose data returns two cycles after the address. The screen is split into 30 horizontal bands, each 16 lines tall. Each band is drawn either as monochrome text or as a colour bitmap. In text mode a band holds 80 character cells of 8x16 pixels. In bitmap mode it holds four rows of a 160x120 image, with every image pixel enlarged to 4x4 screen pixels.

Text and bitmap data share one interleaved address map. Each band's mode comes from a byte stored in column 94 of that band's text row. That column is never drawn. The renderer reads this byte during horizontal blanking of the line just before the band starts, and keeps it for the whole band. Character cell rows are taken from an external character table. The block supplies the character code and the line within the cell, and the table returns eight pixel bits in the same cycle.

Top module: `mixed_scan_renderer`

## Requirements
- R1: In text mode, the read address for screen pixel (h, v) is {3'b111, v[9:4], h[9:3]}, meaning the character row is v/16 and the column is h/8.
- R2: In bitmap mode, the read address for screen pixel (h, v) is {1'b1, h[9:2], v[8:2]}, meaning image x = h/4 and image y = v/4.
- R3: The mode byte for band k is read from {3'b111, k[5:0], 7'd94} when h = 640 on the line before the band. For band 0 that line is the last line of the frame (v = V_TOTAL-1); for band k > 0 it is line 16k-1. No other read of the mode byte occurs. The mode that was read holds for the band's 16 lines, so a change to that byte during the band has no effect until the band's next fetch.
- R4: A mode byte equal to 1 selects bitmap. The value 0, and every other value (for example 2 or 8'h81), selects text. After reset the mode is text.
- R5: For a text pixel, glyph_code carries the character byte and glyph_line carries v mod 16. Bit (7 - h mod 8) of glyph_row selects the pixel, so bit 7 is the leftmost. A set bit gives rgb 6'b111111 and a clear bit gives 0.
- R6: For a bitmap pixel, rgb equals bits [5:0] of the pixel byte, laid out as {r[1:0], g[1:0], b[1:0]}. Bits 7:6 are ignored.
- R7: rgb is 0 for every counter pair with h >= 640 or v >= 480.
- R8: mem_addr shows the address one cycle after the counters are presented. mem_rdata is taken two cycles after that address. rgb for counters (h, v) appears four cycles after they were presented.
- R9: While rst_n is low, rgb and mem_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cnt | input | 10 | Horizontal pixel counter (0..H_TOTAL-1) |
| v_cnt | input | 10 | Vertical line counter (0..V_TOTAL-1) |
| mem_addr | output | 16 | Display memory read address |
| mem_rdata | input | 8 | Display memory read data, two cycles after mem_addr |
| glyph_code | output | 8 | Character code sent to the character table |
| glyph_line | output | 4 | Line within the character cell |
| glyph_row | input | 8 | Cell row bits from the character table, bit 7 leftmost |
| rgb | output | 6 | Pixel colour {r[1:0], g[1:0], b[1:0]} |

## Verification
The embedded properties check on every cycle the following:
- Each mode fetch falls in blanking and targets column 94 of a text row.
- The latched mode changes only when a fetch returns.
- Only the value 1 selects bitmap.
- Text pixels are either full white or black.
- Bitmap pixels copy the low six data bits.
- Nothing non-black leaves for a blanked position.

Other behaviours need the directed scenarios, which compare every address and pixel against a model built from the requirements. These are the exact address interleave, the bit order within a glyph row, and the alignment of the four-cycle pipeline. Also covered this way are the band-0 fetch on the last frame line and the way a rewritten mode byte is ignored until the next band boundary.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
    localparam int CNT_W      = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int RGB_W      = 6;
    localparam int CELL_W_LOG = 3;
    localparam int CELL_H_LOG = 4;
    localparam int SCALE_LOG  = 2;
    localparam int ROW_W      = CNT_W - CELL_H_LOG;
    localparam int COL_W      = CNT_W - CELL_W_LOG;
    localparam int IY_W       = 7;

    // Information about one screen position as it moves down the pipeline
    typedef struct packed {
        logic                  vis;
        logic                  img;
        logic                  fetch;
        logic [CELL_W_LOG-1:0] col;
        logic [CELL_H_LOG-1:0] line;
    } stage_t;
endpackage

// File: rtl/mtr_addr_gen.sv
module mtr_addr_gen
    import mtr_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter int FETCH_H  = 640,
    parameter int MODE_COL = 94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  h_cnt,
    input  logic [CNT_W-1:0]  v_cnt,
    input  logic              mode_img,
    output logic [ADDR_W-1:0] addr_q,
    output stage_t            st_q
);
    localparam logic [CNT_W-1:0] H_ACT_C = CNT_W'(H_ACTIVE);
    localparam logic [CNT_W-1:0] V_ACT_C = CNT_W'(V_ACTIVE);
    localparam logic [CNT_W-1:0] V_PRE_C = CNT_W'(V_ACTIVE - 1);
    localparam logic [CNT_W-1:0] V_END_C = CNT_W'(V_TOTAL - 1);
    localparam logic [CNT_W-1:0] FETCH_C = CNT_W'(FETCH_H);
    localparam logic [COL_W-1:0] MODE_C  = COL_W'(MODE_COL);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        stage_t            st;
    } ag_t;

    ag_t ag_d, ag_q;

    logic             vis_d, last_d, band_end_d, fetch_d;
    logic [ROW_W-1:0] band_nxt_d;

    always_comb begin
        vis_d      = (h_cnt < H_ACT_C) && (v_cnt < V_ACT_C);
        last_d     = (v_cnt == V_END_C);
        band_end_d = (v_cnt < V_PRE_C) && (v_cnt[CELL_H_LOG-1:0] == '1);
        fetch_d    = (h_cnt == FETCH_C) && (last_d || band_end_d);
        band_nxt_d = last_d ? '0 : ROW_W'((v_cnt + CNT_W'(1)) >> CELL_H_LOG);

        ag_d.st.vis   = vis_d;
        ag_d.st.img   = mode_img;
        ag_d.st.fetch = fetch_d;
        ag_d.st.col   = h_cnt[CELL_W_LOG-1:0];
        ag_d.st.line  = v_cnt[CELL_H_LOG-1:0];

        if (fetch_d) begin
            ag_d.addr = {3'b111, band_nxt_d, MODE_C};
        end else if (mode_img) begin
            ag_d.addr = {1'b1, h_cnt[CNT_W-1:SCALE_LOG],
                         v_cnt[SCALE_LOG+IY_W-1:SCALE_LOG]};
        end else begin
            ag_d.addr = {3'b111, v_cnt[CNT_W-1:CELL_H_LOG],
                         h_cnt[CNT_W-1:CELL_W_LOG]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign addr_q = ag_q.addr;
    assign st_q   = ag_q.st;

    // R3: a mode fetch never steals a visible pixel's read slot
    a_r3_fetch_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fetch |-> !st_q.vis);

    // R3: a mode fetch targets the unused column of a text row
    a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fetch |-> (addr_q[COL_W-1:0] == MODE_C && addr_q[ADDR_W-1:ADDR_W-3] == 3'b111));
endmodule

// File: rtl/mtr_mode_reg.sv
module mtr_mode_reg
    import mtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_ret,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mode_img
);
    logic mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (fetch_ret) begin
            mode_d = (mem_rdata == DATA_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_img = mode_q;

    // R3: band mode changes only when a fetched byte returns
    a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ret |=> $stable(mode_img));

    // R4: any returned value other than 1 leaves the band in text mode
    a_r4_only_one_is_image: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ret && mem_rdata != DATA_W'(1)) |=> !mode_img);
endmodule

// File: rtl/mtr_pix_out.sv
module mtr_pix_out
    import mtr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  stage_t                st_in,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic [DATA_W-1:0]     glyph_row,
    output logic [DATA_W-1:0]     glyph_code,
    output logic [CELL_H_LOG-1:0] glyph_line,
    output logic                  fetch_ret,
    output logic [RGB_W-1:0]      rgb
);
    localparam logic [CELL_W_LOG-1:0] LEFT_BIT = CELL_W_LOG'(DATA_W - 1);

    typedef struct packed {
        stage_t           s2;
        stage_t           s3;
        logic [RGB_W-1:0] rgb;
    } po_t;

    po_t po_d, po_q;

    logic glyph_bit_d;

    always_comb begin
        glyph_bit_d = glyph_row[LEFT_BIT - po_q.s3.col];
        po_d.s2 = st_in;
        po_d.s3 = po_q.s2;
        if (!po_q.s3.vis) begin
            po_d.rgb = '0;
        end else if (po_q.s3.img) begin
            po_d.rgb = mem_rdata[RGB_W-1:0];
        end else begin
            po_d.rgb = glyph_bit_d ? '1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            po_q <= '0;
        end else begin
            po_q <= po_d;
        end
    end

    assign glyph_code = mem_rdata;
    assign glyph_line = po_q.s3.line;
    assign fetch_ret  = po_q.s3.fetch;
    assign rgb        = po_q.rgb;

    // R7: a non-black output must come from a visible position
    a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb != '0) |-> $past(po_q.s3.vis));

    // R5: text pixels are full white or black
    a_r5_mono: assert property (@(posedge clk) disable iff (!rst_n)
        (po_q.s3.vis && !po_q.s3.img) |=> (rgb == '0 || rgb == '1));

    // R6: bitmap pixels carry the low six data bits
    a_r6_image_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (po_q.s3.vis && po_q.s3.img) |=> (rgb == $past(mem_rdata[RGB_W-1:0])));
endmodule

// File: rtl/mixed_scan_renderer.sv
module mixed_scan_renderer
    import mtr_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter int FETCH_H  = 640,
    parameter int MODE_COL = 94
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      h_cnt,
    input  logic [CNT_W-1:0]      v_cnt,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     glyph_code,
    output logic [CELL_H_LOG-1:0] glyph_line,
    input  logic [DATA_W-1:0]     glyph_row,
    output logic [RGB_W-1:0]      rgb
);
    logic   mode_img;
    logic   fetch_ret;
    stage_t st1;

    mtr_addr_gen #(
        .H_ACTIVE (H_ACTIVE),
        .V_ACTIVE (V_ACTIVE),
        .V_TOTAL  (V_TOTAL),
        .FETCH_H  (FETCH_H),
        .MODE_COL (MODE_COL)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_cnt    (h_cnt),
        .v_cnt    (v_cnt),
        .mode_img (mode_img),
        .addr_q   (mem_addr),
        .st_q     (st1)
    );

    mtr_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_ret (fetch_ret),
        .mem_rdata (mem_rdata),
        .mode_img  (mode_img)
    );

    mtr_pix_out u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_in      (st1),
        .mem_rdata  (mem_rdata),
        .glyph_row  (glyph_row),
        .glyph_code (glyph_code),
        .glyph_line (glyph_line),
        .fetch_ret  (fetch_ret),
        .rgb        (rgb)
    );
endmodule

// File: tb/mixed_scan_renderer_test.sv
module mixed_scan_renderer_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  VT = 525;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  h_cnt = 10'd700;
    logic [9:0]  v_cnt = 10'd500;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  glyph_code;
    logic [3:0]  glyph_line;
    logic [7:0]  glyph_row;
    logic [5:0]  rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] mode_tab [0:31];
    logic       exp_img = 1'b0;

    // pixel expectation history (index 3 = four steps ago)
    logic [5:0] h_rgb [0:3];
    logic       h_val [0:3];
    string      h_kind [0:3];
    string      h_scen [0:3];
    logic [15:0] pa_exp;
    string       pa_kind = "";
    string       pa_scen = "";

    always #(CLK_PERIOD / 2) clk = ~clk;

    mixed_scan_renderer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .glyph_code (glyph_code),
        .glyph_line (glyph_line),
        .glyph_row  (glyph_row),
        .rgb        (rgb)
    );

    function automatic logic [7:0] memv(input logic [15:0] a);
        if (a[15:13] == 3'b111 && a[6:0] == 7'd94 && a[12] == 1'b0)
            return mode_tab[a[11:7]];
        return a[7:0] ^ a[15:8] ^ 8'hA5 ^ {a[3:0], a[15:12]};
    endfunction

    function automatic logic [7:0] font(input logic [7:0] c, input logic [3:0] l);
        return c ^ {l, ~l};
    endfunction

    // display memory with two-cycle read latency; combinational character table
    logic [7:0] rd_p1 = 8'h00;
    logic [7:0] rd_p2 = 8'h00;
    always @(posedge clk) begin
        rd_p1 <= memv(mem_addr);
        rd_p2 <= rd_p1;
    end
    assign mem_rdata = rd_p2;
    assign glyph_row = font(glyph_code, glyph_line);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic is_fetch(input logic [9:0] hh, input logic [9:0] vv);
        return (hh == 10'd640) && ((vv == 10'(VT - 1)) || (vv < 10'd479 && vv[3:0] == 4'hF));
    endfunction

    // one pixel-clock step: check outputs, then present new counters
    task automatic step(input logic [9:0] hh, input logic [9:0] vv, input string scen);
        logic vis;
        logic [15:0] a;
        logic [7:0] code;
        logic [7:0] g;
        logic [5:0] e;
        logic [5:0] nb;
        @(negedge clk);
        if (h_val[3]) chk({h_scen[3], "/", h_kind[3]}, 16'(rgb), 16'(h_rgb[3]));
        if (pa_kind != "") chk({pa_scen, "/", pa_kind}, mem_addr, pa_exp);
        for (int i = 3; i > 0; i--) begin
            h_rgb[i] = h_rgb[i-1]; h_val[i] = h_val[i-1];
            h_kind[i] = h_kind[i-1]; h_scen[i] = h_scen[i-1];
        end
        vis = (hh < 10'd640) && (vv < 10'd480);
        pa_kind = "";
        pa_scen = scen;
        e = 6'd0;
        if (is_fetch(hh, vv)) begin
            nb = (vv == 10'(VT - 1)) ? 6'd0 : 6'((vv + 10'd1) >> 4);
            pa_exp = {3'b111, nb, 7'd94};
            pa_kind = "R3";
            exp_img = (mode_tab[nb[4:0]] == 8'd1);
            h_kind[0] = "R7";
        end else if (!vis) begin
            h_kind[0] = "R7";
        end else if (exp_img) begin
            a = {1'b1, hh[9:2], vv[8:2]};
            e = memv(a) & 8'h3F;
            pa_exp = a; pa_kind = "R2"; h_kind[0] = "R6";
        end else begin
            a = {3'b111, vv[9:4], hh[9:3]};
            code = memv(a);
            g = font(code, vv[3:0]);
            e = g[3'd7 - hh[2:0]] ? 6'h3F : 6'h00;
            pa_exp = a; pa_kind = "R1"; h_kind[0] = "R5";
        end
        h_rgb[0] = e; h_val[0] = 1'b1; h_scen[0] = scen;
        h_cnt = hh;
        v_cnt = vv;
    endtask

    task automatic run_line(input int vv, input string scen);
        for (int hh = 0; hh < 800; hh++) step(10'(hh), 10'(vv), scen);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) h_val[i] = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9 rgb in reset", 16'(rgb), 16'h0);
        chk("R9 addr in reset", mem_addr, 16'h0);
        rst_n = 1'b1;
        run_line(0, "R9 text after reset");
    endtask

    task automatic t_text();
        mode_tab[1] = 8'd0;
        run_line(15, "R1 R5 fetch");
        run_line(16, "R1 R5 text");
        run_line(23, "R1 R5 text");
    endtask

    task automatic t_image();
        mode_tab[2] = 8'd1;
        run_line(31, "R2 R6 fetch");
        run_line(32, "R2 R6 image");
        run_line(35, "R2 R6 image");
    endtask

    task automatic t_hold();
        mode_tab[2] = 8'd0;
        run_line(40, "R3 mid-band rewrite ignored");
        mode_tab[3] = 8'd1;
        run_line(47, "R3 fetch band3");
        run_line(48, "R3 band3 image");
    endtask

    task automatic t_odd_mode();
        mode_tab[4] = 8'd2;
        run_line(63, "R4 fetch value 2");
        run_line(64, "R4 value 2 is text");
        mode_tab[5] = 8'h81;
        run_line(79, "R4 fetch value 81");
        run_line(80, "R4 value 81 is text");
    endtask

    task automatic t_band0_blank();
        run_line(479, "R7 last visible-adjacent");
        run_line(500, "R7 vertical blank");
        mode_tab[0] = 8'd1;
        run_line(VT - 1, "R3 band0 fetch");
        run_line(0, "R3 band0 image");
    endtask

    task automatic t_latency();
        repeat (3) step(10'd700, 10'd0, "R8 blank lead");
        step(10'd8, 10'd0, "R8 single pixel");
        step(10'd700, 10'd0, "R8 blank after");
        step(10'd20, 10'd3, "R8 hop");
        step(10'd636, 10'd2, "R8 hop");
        repeat (6) step(10'd700, 10'd0, "R8 drain");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mode_tab[i] = 8'd0;
        t_reset();
        t_text();
        t_image();
        t_hold();
        t_odd_mode();
        t_band0_blank();
        t_latency();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R8 act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule